// File: doc/BRIEF.md
# Partitioned SIMD Vector ALU

This block is a vector arithmetic unit for a SIMD datapath. A vector is `LANES` 32-bit lanes wide (`LANES` even, default 4, so 128 bits). A 20-bit vector instruction names a destination and two source registers in a 16-entry vector register file, an operation and an element width. Each vector is treated as a row of independent elements of 8, 16, 32 or 64 bits. Additions, subtractions, bitwise logic and single-bit shifts act on every element at once, and no carry or shifted bit crosses from one element into the next. In 64-bit mode each pair of neighbouring 32-bit lanes is joined into one element.

The register file has a host write port and a combinational host read port. These let surrounding logic place operands and collect results. An instruction presented with `instr_valid_i` high executes in one clock. Its result is written to the destination register and also held on `result_o`. Any instruction that is not an ALU-class instruction with a defined operation is ignored.

Top module: `vec_alu_top`

## Requirements
- R1: After reset every register reads zero and `result_o` is zero.
- R2: When `wr_en_i` is high at a clock edge, `wr_data_i` is stored in register `wr_idx_i`. `rd_data_o` always shows register `rd_idx_i` combinationally.
- R3: The instruction fields are as follows. Bits [19:18] are the class, and 01 marks an ALU instruction. Bits [17:16] are the element width. Bits [15:12] are the operation. Bits [11:8] are the destination, [7:4] the first source and [3:0] the second source. At a clock edge where `instr_valid_i` is high and the instruction is legal, the result is written to the destination register and to `result_o`, and both are visible after that edge.
- R4: Operation 0000 adds. Each element gets (a + b) mod 2^W, where the width code 00, 01, 10 or 11 selects W = 8, 16, 32 or 64.
- R5: Operation 0010 subtracts. Each element gets (a - b) mod 2^W with no saturation, and no borrow passes between elements.
- R6: Operations 1000, 1001 and 1010 give the bitwise AND, OR and XOR of the two sources.
- R7: Operation 1100 shifts each element left by one bit. A zero enters at the element's least significant bit and the element's top bit is dropped.
- R8: Operation 1110 shifts each element right by one bit. A zero enters at the element's most significant bit.
- R9: With width code 11, lanes 2i and 2i+1 form one 64-bit element. Carry, borrow and shifted bits pass between those two lanes, and never between lane 2i+1 and lane 2i+2.
- R10: An instruction whose class is not 01, or whose operation is not one of 0000, 0010, 1000, 1001, 1010, 1100 or 1110 (this includes the multiply code 1011), changes no register and does not change `result_o`.
- R11: If an instruction and the host port write the same register at the same edge, the instruction result is stored. Writes to different registers at the same edge both take effect.
- R12: The destination may equal a source. The sources are read as they were before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Execute `instr_i` at this edge |
| instr_i | input | 20 | Vector instruction |
| wr_en_i | input | 1 | Host register write enable |
| wr_idx_i | input | 4 | Host write register index |
| wr_data_i | input | LANES*32 | Host write data |
| rd_idx_i | input | 4 | Host read register index |
| rd_data_o | output | LANES*32 | Host read data, combinational |
| result_o | output | LANES*32 | Result of the last executed instruction |

## Verification
Every operation runs at all four element widths against four operand pairs. The first pair is all-ones plus a one in every byte: a sum of zero shows that carries stop at each byte, and any other value shows that they leak. The second pair is zero minus that same one-per-byte pattern, which tests borrow cutting in the same way. The remaining pairs set the top and bottom bits at lane and element edges, so a shift that drops or carries a bit across the wrong boundary shows up, including the 32-bit lane seams that 64-bit mode must join. Directed cases cover field decoding, illegal classes and opcodes, a destination that is also a source, and a host write to the same register as an instruction in the same cycle.

// File: rtl/vec_alu_pkg.sv
package vec_alu_pkg;
  localparam int unsigned INSTR_W   = 20;
  localparam int unsigned REG_IDX_W = 4;
  localparam logic [1:0]  CLASS_ALU = 2'b01;

  typedef enum logic [1:0] {
    EW_8  = 2'b00,
    EW_16 = 2'b01,
    EW_32 = 2'b10,
    EW_64 = 2'b11
  } elem_w_e;

  typedef enum logic [3:0] {
    OP_ADD = 4'b0000,
    OP_SUB = 4'b0010,
    OP_AND = 4'b1000,
    OP_OR  = 4'b1001,
    OP_XOR = 4'b1010,
    OP_MUL = 4'b1011,
    OP_SHL = 4'b1100,
    OP_SHR = 4'b1110
  } valu_op_e;

  typedef struct packed {
    logic [1:0]           cls;
    logic [1:0]           ew;
    logic [3:0]           op;
    logic [REG_IDX_W-1:0] rd;
    logic [REG_IDX_W-1:0] rs1;
    logic [REG_IDX_W-1:0] rs2;
  } vinstr_t;
endpackage

// File: rtl/vec_alu_decode.sv
module vec_alu_decode
  import vec_alu_pkg::*;
(
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic                 valid_i,
  output logic                 exec_o,
  output valu_op_e             op_o,
  output elem_w_e              ew_o,
  output logic [REG_IDX_W-1:0] rd_o,
  output logic [REG_IDX_W-1:0] rs1_o,
  output logic [REG_IDX_W-1:0] rs2_o
);
  vinstr_t ins;
  logic    op_known;

  assign ins   = vinstr_t'(instr_i);
  assign op_o  = valu_op_e'(ins.op);
  assign ew_o  = elem_w_e'(ins.ew);
  assign rd_o  = ins.rd;
  assign rs1_o = ins.rs1;
  assign rs2_o = ins.rs2;

  // multiply is not built: its code falls through as illegal
  always_comb begin
    unique case (ins.op)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR: op_known = 1'b1;
      default:                                               op_known = 1'b0;
    endcase
  end

  assign exec_o = valid_i && (ins.cls == CLASS_ALU) && op_known;
endmodule

// File: rtl/vec_alu_regfile.sv
module vec_alu_regfile #(
  parameter int unsigned WIDTH = 128,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alu_we_i,
  input  logic [IW-1:0]    alu_idx_i,
  input  logic [WIDTH-1:0] alu_data_i,
  input  logic             host_we_i,
  input  logic [IW-1:0]    host_idx_i,
  input  logic [WIDTH-1:0] host_data_i,
  input  logic [IW-1:0]    ra_idx_i,
  input  logic [IW-1:0]    rb_idx_i,
  input  logic [IW-1:0]    rc_idx_i,
  output logic [WIDTH-1:0] ra_data_o,
  output logic [WIDTH-1:0] rb_data_o,
  output logic [WIDTH-1:0] rc_data_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic             host_go;

  assign host_go = host_we_i && !(alu_we_i && (alu_idx_i == host_idx_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else begin
      if (host_go)  mem[host_idx_i] <= host_data_i;
      if (alu_we_i) mem[alu_idx_i]  <= alu_data_i;
    end
  end

  assign ra_data_o = mem[ra_idx_i];
  assign rb_data_o = mem[rb_idx_i];
  assign rc_data_o = mem[rc_idx_i];

  p_host_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_go |=> mem[$past(host_idx_i)] == $past(host_data_i));

  p_alu_write_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_we_i |=> mem[$past(alu_idx_i)] == $past(alu_data_i));
endmodule

// File: rtl/vec_alu_lane.sv
module vec_alu_lane
  import vec_alu_pkg::*;
(
  input  logic [31:0] a_i,
  input  logic [31:0] b_i,
  input  valu_op_e    op_i,
  input  elem_w_e     ew_i,
  input  logic        cin_i,     // carry into byte 0
  input  logic        shl_in_i,  // bit entering position 0 on left shift
  input  logic        shr_in_i,  // bit entering position 31 on right shift
  output logic [31:0] res_o,
  output logic        cout_o
);
  logic        sub;
  logic [31:0] bx, sum, shl, shr;
  logic [3:0]  cin_b, cout_b;

  assign sub = (op_i == OP_SUB);
  assign bx  = sub ? ~b_i : b_i;

  for (genvar k = 0; k < 4; k++) begin : g_byte
    logic [8:0] t;
    if (k == 0) begin : g_first
      assign cin_b[k] = cin_i;
    end else begin : g_rest
      logic cut;
      assign cut      = (ew_i == EW_8) || ((ew_i == EW_16) && (k == 2));
      assign cin_b[k] = cut ? sub : cout_b[k-1];
    end
    assign t                = {1'b0, a_i[8*k +: 8]} + {1'b0, bx[8*k +: 8]} + {8'b0, cin_b[k]};
    assign sum[8*k +: 8]    = t[7:0];
    assign cout_b[k]        = t[8];
  end
  assign cout_o = cout_b[3];

  for (genvar j = 0; j < 32; j++) begin : g_bit
    localparam bit LO8  = (j % 8)  == 0;
    localparam bit LO16 = (j % 16) == 0;
    localparam bit HI8  = (j % 8)  == 7;
    localparam bit HI16 = (j % 16) == 15;
    if (j == 0) begin : g_lo
      assign shl[j] = shl_in_i;
    end else begin : g_lo_n
      assign shl[j] = ((ew_i == EW_8 && LO8) || (ew_i == EW_16 && LO16)) ? 1'b0 : a_i[j-1];
    end
    if (j == 31) begin : g_hi
      assign shr[j] = shr_in_i;
    end else begin : g_hi_n
      assign shr[j] = ((ew_i == EW_8 && HI8) || (ew_i == EW_16 && HI16)) ? 1'b0 : a_i[j+1];
    end
  end

  always_comb begin
    unique case (op_i)
      OP_ADD, OP_SUB: res_o = sum;
      OP_AND:         res_o = a_i & b_i;
      OP_OR:          res_o = a_i | b_i;
      OP_XOR:         res_o = a_i ^ b_i;
      OP_SHL:         res_o = shl;
      OP_SHR:         res_o = shr;
      default:        res_o = '0;
    endcase
  end

  always_comb begin
    if (op_i == OP_SHL && ew_i == EW_8)
      p_shl_byte_lsb_zero_r7: assert ((res_o & 32'h0101_0101) == 32'h0);
    if (op_i == OP_SHR && ew_i == EW_8)
      p_shr_byte_msb_zero_r8: assert ((res_o & 32'h8080_8080) == 32'h0);
  end
endmodule

// File: rtl/vec_alu_top.sv
module vec_alu_top
  import vec_alu_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned NREGS = 16,
  localparam int unsigned VW   = LANES * 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 instr_valid_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic                 wr_en_i,
  input  logic [REG_IDX_W-1:0] wr_idx_i,
  input  logic [VW-1:0]        wr_data_i,
  input  logic [REG_IDX_W-1:0] rd_idx_i,
  output logic [VW-1:0]        rd_data_o,
  output logic [VW-1:0]        result_o
);
  logic                 exec;
  valu_op_e             op;
  elem_w_e              ew;
  logic [REG_IDX_W-1:0] rd, rs1, rs2;
  logic [VW-1:0]        a_vec, b_vec, alu_res, result_q;
  logic [LANES-1:0]     lane_cout;
  logic                 sub;

  assign sub = (op == OP_SUB);

  vec_alu_decode u_dec (
    .instr_i (instr_i),
    .valid_i (instr_valid_i),
    .exec_o  (exec),
    .op_o    (op),
    .ew_o    (ew),
    .rd_o    (rd),
    .rs1_o   (rs1),
    .rs2_o   (rs2)
  );

  vec_alu_regfile #(.WIDTH(VW), .DEPTH(NREGS)) u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alu_we_i    (exec),
    .alu_idx_i   (rd),
    .alu_data_i  (alu_res),
    .host_we_i   (wr_en_i),
    .host_idx_i  (wr_idx_i),
    .host_data_i (wr_data_i),
    .ra_idx_i    (rs1),
    .rb_idx_i    (rs2),
    .rc_idx_i    (rd_idx_i),
    .ra_data_o   (a_vec),
    .rb_data_o   (b_vec),
    .rc_data_o   (rd_data_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic cin, shl_in, shr_in;
    // odd lane is the upper half of a 64-bit element; even lane the lower
    if (l % 2 == 1) begin : g_odd
      assign cin    = (ew == EW_64) ? lane_cout[l-1] : sub;
      assign shl_in = (ew == EW_64) ? a_vec[32*(l-1) + 31] : 1'b0;
      assign shr_in = 1'b0;
    end else begin : g_even
      assign cin    = sub;
      assign shl_in = 1'b0;
      assign shr_in = (ew == EW_64) ? a_vec[32*(l+1)] : 1'b0;
    end
    vec_alu_lane u_lane (
      .a_i      (a_vec[32*l +: 32]),
      .b_i      (b_vec[32*l +: 32]),
      .op_i     (op),
      .ew_i     (ew),
      .cin_i    (cin),
      .shl_in_i (shl_in),
      .shr_in_i (shr_in),
      .res_o    (alu_res[32*l +: 32]),
      .cout_o   (lane_cout[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   result_q <= '0;
    else if (exec) result_q <= alu_res;
  end
  assign result_o = result_q;

  logic [7:0] byte0_sum_chk;
  assign byte0_sum_chk = a_vec[7:0] + b_vec[7:0];

  p_idle_holds_result_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec |=> $stable(result_o));

  p_xor_self_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && op == OP_XOR && rs1 == rs2) |=> (result_o == '0));

  p_sub_self_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && op == OP_SUB && rs1 == rs2) |=> (result_o == '0));

  p_add_byte0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && op == OP_ADD && ew == EW_8) |=> (result_o[7:0] == $past(byte0_sum_chk)));
endmodule

// File: tb/tb_vec_alu_top.sv
`timescale 1ns/1ps
module tb_vec_alu_top;
  localparam int LANES = 4;
  localparam int VW    = LANES * 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          instr_valid;
  logic [19:0]   instr;
  logic          wr_en;
  logic [3:0]    wr_idx;
  logic [VW-1:0] wr_data;
  logic [3:0]    rd_idx;
  logic [VW-1:0] rd_data;
  logic [VW-1:0] result;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  vec_alu_top #(.LANES(LANES)) dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .instr_valid_i (instr_valid),
    .instr_i       (instr),
    .wr_en_i       (wr_en),
    .wr_idx_i      (wr_idx),
    .wr_data_i     (wr_data),
    .rd_idx_i      (rd_idx),
    .rd_data_o     (rd_data),
    .result_o      (result)
  );

  function automatic logic [19:0] mk(input logic [1:0] cls, input logic [1:0] ew,
                                     input logic [3:0] op, input logic [3:0] d,
                                     input logic [3:0] s1, input logic [3:0] s2);
    return {cls, ew, op, d, s1, s2};
  endfunction

  function automatic logic [VW-1:0] model(input logic [3:0] op, input logic [1:0] ew,
                                          input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [VW-1:0] res;
    logic [63:0]   m, x, y, r;
    int            w;
    res = '0;
    w   = 8 << ew;
    m   = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    for (int e = 0; e < VW / w; e++) begin
      x = 64'(a >> (e * w)) & m;
      y = 64'(b >> (e * w)) & m;
      case (op)
        4'b0000: r = x + y;
        4'b0010: r = x - y;
        4'b1000: r = x & y;
        4'b1001: r = x | y;
        4'b1010: r = x ^ y;
        4'b1100: r = x << 1;
        4'b1110: r = x >> 1;
        default: r = '0;
      endcase
      r   = r & m;
      res = res | (VW'(r) << (e * w));
    end
    return res;
  endfunction

  task automatic chk(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] idx, input logic [VW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] idx, output logic [VW-1:0] d);
    rd_idx = idx;
    #1;
    d = rd_data;
  endtask

  task automatic exec(input logic [19:0] ins);
    @(negedge clk);
    instr_valid = 1'b1; instr = ins;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [VW-1:0] v;
    chk("R1 result after reset", result, '0);
    for (int i = 0; i < 16; i++) begin
      rd_reg(4'(i), v);
      chk("R1 register after reset", v, '0);
    end
  endtask

  task automatic t_host_port();
    logic [VW-1:0] v;
    wr_reg(4'd14, {4{32'hdead_beef}});
    wr_reg(4'd0,  {4{32'h1234_5678}});
    rd_reg(4'd14, v);
    chk("R2 host write/read r14", v, {4{32'hdead_beef}});
    rd_reg(4'd0, v);
    chk("R2 host write/read r0", v, {4{32'h1234_5678}});
  endtask

  task automatic t_ops(input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [3:0]    ops [7] = '{4'b0000, 4'b0010, 4'b1000, 4'b1001, 4'b1010, 4'b1100, 4'b1110};
    logic [VW-1:0] v, exp;
    string         tag;
    wr_reg(4'd1, a);
    wr_reg(4'd2, b);
    for (int w = 0; w < 4; w++) begin
      for (int k = 0; k < 7; k++) begin
        case (ops[k])
          4'b0000: tag = "R4 add";
          4'b0010: tag = "R5 sub";
          4'b1100: tag = "R7 shl";
          4'b1110: tag = "R8 shr";
          default: tag = "R6 logic";
        endcase
        if (w == 3 && ops[k] != 4'b1000 && ops[k] != 4'b1001 && ops[k] != 4'b1010)
          tag = {"R9 joined ", tag};
        exp = model(ops[k], 2'(w), a, b);
        exec(mk(2'b01, 2'(w), ops[k], 4'd3, 4'd1, 4'd2));
        rd_reg(4'd3, v);
        chk(tag, v, exp);
        chk({tag, " result_o"}, result, exp);
      end
    end
  endtask

  task automatic t_fields();
    logic [VW-1:0] a, b, v;
    a = 128'h0000_0005_0000_0000_ffff_0000_1111_2222;
    b = 128'h0000_0003_0000_0001_0001_0001_0101_0202;
    wr_reg(4'd7, a);
    wr_reg(4'd12, b);
    exec(mk(2'b01, 2'b10, 4'b0010, 4'd5, 4'd7, 4'd12));
    rd_reg(4'd5, v);
    chk("R3 field order rd=5 rs1=7 rs2=12", v, model(4'b0010, 2'b10, a, b));
    rd_reg(4'd7, v);
    chk("R3 source r7 untouched", v, a);
    rd_reg(4'd12, v);
    chk("R3 source r12 untouched", v, b);
  endtask

  task automatic t_illegal();
    logic [19:0]   bad_ins [7];
    logic [VW-1:0] keep, res_before, v;
    bad_ins[0] = mk(2'b00, 2'b00, 4'b0000, 4'd9, 4'd1, 4'd2);
    bad_ins[1] = mk(2'b10, 2'b00, 4'b0000, 4'd9, 4'd1, 4'd2);
    bad_ins[2] = mk(2'b11, 2'b01, 4'b1000, 4'd9, 4'd1, 4'd2);
    bad_ins[3] = mk(2'b01, 2'b10, 4'b1011, 4'd9, 4'd1, 4'd2);
    bad_ins[4] = mk(2'b01, 2'b00, 4'b0001, 4'd9, 4'd1, 4'd2);
    bad_ins[5] = mk(2'b01, 2'b00, 4'b0100, 4'd9, 4'd1, 4'd2);
    bad_ins[6] = mk(2'b01, 2'b11, 4'b1111, 4'd9, 4'd1, 4'd2);
    keep = {4{32'h5a5a_a5a5}};
    wr_reg(4'd9, keep);
    res_before = result;
    for (int i = 0; i < 7; i++) begin
      exec(bad_ins[i]);
      rd_reg(4'd9, v);
      chk("R10 illegal instr leaves register", v, keep);
      chk("R10 illegal instr leaves result_o", result, res_before);
    end
  endtask

  task automatic t_collide();
    logic [VW-1:0] a, b, v, exp;
    a = {4{32'h0102_0304}};
    b = {4{32'h1010_1010}};
    wr_reg(4'd1, a);
    wr_reg(4'd2, b);
    exp = model(4'b0000, 2'b00, a, b);
    @(negedge clk);
    instr_valid = 1'b1; instr = mk(2'b01, 2'b00, 4'b0000, 4'd6, 4'd1, 4'd2);
    wr_en = 1'b1; wr_idx = 4'd6; wr_data = '1;
    @(negedge clk);
    instr_valid = 1'b0; wr_en = 1'b0;
    rd_reg(4'd6, v);
    chk("R11 same-register collision keeps instr result", v, exp);
    @(negedge clk);
    instr_valid = 1'b1; instr = mk(2'b01, 2'b00, 4'b1010, 4'd6, 4'd1, 4'd2);
    wr_en = 1'b1; wr_idx = 4'd8; wr_data = {4{32'hcafe_f00d}};
    @(negedge clk);
    instr_valid = 1'b0; wr_en = 1'b0;
    rd_reg(4'd6, v);
    chk("R11 distinct regs: instr write", v, a ^ b);
    rd_reg(4'd8, v);
    chk("R11 distinct regs: host write", v, {4{32'hcafe_f00d}});
  endtask

  task automatic t_alias();
    logic [VW-1:0] a, b, v;
    a = 128'hffff_ffff_0000_0001_8000_0000_7fff_ffff;
    b = 128'h0000_0001_ffff_ffff_8000_0000_0000_0001;
    wr_reg(4'd1, a);
    wr_reg(4'd2, b);
    exec(mk(2'b01, 2'b11, 4'b0000, 4'd1, 4'd1, 4'd2));
    rd_reg(4'd1, v);
    chk("R12 rd equals rs1 uses old value", v, model(4'b0000, 2'b11, a, b));
    exec(mk(2'b01, 2'b00, 4'b1100, 4'd2, 4'd2, 4'd2));
    rd_reg(4'd2, v);
    chk("R12 rd equals both sources", v, model(4'b1100, 2'b00, b, b));
  endtask

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; instr = '0;
    wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_host_port();
    t_ops('1, {16{8'h01}});
    t_ops('0, {16{8'h01}});
    t_ops(128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
          128'h00ff_00ff_8000_7fff_ffff_ffff_0000_0001);
    t_ops(128'h8000_0001_8080_8080_0101_0101_8000_0001,
          128'h7f7f_7f7f_7f7f_7f7f_ffff_ffff_ffff_ffff);
    t_fields();
    t_illegal();
    t_collide();
    t_alias();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule